// File: doc/BRIEF.md
# Width Scaled Sign Extension Unit

This block widens a signed field held in the low bits of an operand so that it fills the active register width. The register width is chosen at run time as 8, 16, 32 or 64 bits. In scaled mode the three operations take a field whose size is a fixed fraction of that width: one eighth, one quarter or one half. In fixed-size mode the fields are always 8, 16 and 32 bits, whatever the width.

When a fixed-size field is as wide as the register, the low register bits are copied through unchanged. When the field is wider than the register, the result is the low register bits, cut off at the register width. At 64-bit width the two modes give the same result. The result is registered, and it appears one cycle after a valid strobe together with an output valid flag. Bits at and above the register width are always zero.

Top module: `xsext_unit`

## Requirements
- R1: Width select `xw_sel` encodes the register width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. Every result bit at or above that width is 0.
- R2: In scaled mode (`fixed_sz`=0), operation 00 sign-extends the low width/8 bits of `src` to the full register width.
- R3: In scaled mode, operation 01 sign-extends the low width/4 bits, and operation 10 sign-extends the low width/2 bits.
- R4: The sign bit is the top bit of the selected field. It is copied into every result bit from the top of the field up to the register width.
- R5: In fixed-size mode (`fixed_sz`=1), operations 00, 01 and 10 use fields of 8, 16 and 32 bits. A field equal to or wider than the register passes the low register bits through unchanged.
- R6: At 64-bit width, fixed-size and scaled modes give the same result for every operation.
- R7: Operation 11 passes the low register bits through and sets `illegal` to 1. Every other operation sets `illegal` to 0.
- R8: `out_vld` is 1 exactly in the cycle after `in_vld` was 1. `res` and `illegal` update only in that cycle and hold their values otherwise. Reset clears `res`, `illegal` and `out_vld` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Input valid strobe |
| src | input | 64 | Source operand |
| op | input | 2 | 00 byte, 01 half, 10 word, 11 illegal |
| xw_sel | input | 2 | Register width: 0=8, 1=16, 2=32, 3=64 |
| fixed_sz | input | 1 | 1 selects fixed 8/16/32-bit field sizes |
| res | output | 64 | Registered result, zero above the width |
| illegal | output | 1 | Registered flag for operation 11 |
| out_vld | output | 1 | Result valid, one cycle after in_vld |

## Verification
The directed cases place a 1 in the sign bit of the field and 0s just above it, so a field of the wrong size leaves visible ones or zeros in the result. One-bit fields at 8-bit width check that a field of a single bit can still be sign-extended. Fixed-size cases at widths of 8 and 16 bits catch a design that extends where it should truncate. In all cases, stray bits in the source above the register width show up if the design fails to clear the high bits. Random cycles with `in_vld` low catch results that change without a strobe.

// File: rtl/xsext_unit.sv
module xsext_unit #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [DW-1:0] src,
  input  logic [1:0]    op,
  input  logic [1:0]    xw_sel,
  input  logic          fixed_sz,
  output logic [DW-1:0] res,
  output logic          illegal,
  output logic          out_vld
);
  localparam int LW = $clog2(DW) + 1;

  logic [LW-1:0] xlen, fld;
  logic [DW-1:0] wmask, fmask, nxt;
  logic          sgn;

  assign xlen = LW'(8) << xw_sel;

  always_comb begin
    if (op == 2'b11) fld = xlen;
    else if (fixed_sz) fld = (LW'(8) << op) > xlen ? xlen : (LW'(8) << op);
    else fld = xlen >> (2'd3 - op);
  end

  assign wmask = (xlen >= LW'(DW)) ? '1 : ((DW'(1) << xlen) - DW'(1));
  assign fmask = (fld >= LW'(DW)) ? '1 : ((DW'(1) << fld) - DW'(1));
  assign sgn   = src[fld - LW'(1)];
  assign nxt   = ((src & fmask) | ({DW{sgn}} & ~fmask)) & wmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res     <= '0;
      illegal <= 1'b0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        res     <= nxt;
        illegal <= (op == 2'b11);
      end
    end
  end
endmodule

module xsext_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_vld,
  input logic [63:0] src,
  input logic [1:0]  op,
  input logic [1:0]  xw_sel,
  input logic        fixed_sz,
  input logic [63:0] res,
  input logic        illegal,
  input logic        out_vld
);
  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_vld |=> out_vld); // R8
  AST_VLD_DROPS: assert property (@(posedge clk) disable iff (!rst_n) !in_vld |=> !out_vld); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_vld |=> ($stable(res) && $stable(illegal))); // R8
  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n) in_vld |=> (illegal == ($past(op) == 2'b11))); // R7
  AST_HIGH_ZERO_8: assert property (@(posedge clk) disable iff (!rst_n) (in_vld && xw_sel == 2'd0) |=> (res[63:8] == '0)); // R1
  AST_HIGH_ZERO_16: assert property (@(posedge clk) disable iff (!rst_n) (in_vld && xw_sel == 2'd1) |=> (res[63:16] == '0)); // R1
  AST_HIGH_ZERO_32: assert property (@(posedge clk) disable iff (!rst_n) (in_vld && xw_sel == 2'd2) |=> (res[63:32] == '0)); // R1
  AST_BYTE64_SIGN: assert property (@(posedge clk) disable iff (!rst_n) (in_vld && xw_sel == 2'd3 && op == 2'b00) |=> (res[63:8] == {56{$past(src[7])}})); // R6
endmodule

bind xsext_unit xsext_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .src(src), .op(op),
  .xw_sel(xw_sel), .fixed_sz(fixed_sz), .res(res), .illegal(illegal), .out_vld(out_vld)
);

// File: tb/xsext_unit_tb.sv
module xsext_unit_tb_top;
  logic        clk = 0, rst_n = 0, in_vld = 0, fixed_sz = 0;
  logic [63:0] src = '0;
  logic [1:0]  op = 0, xw_sel = 0;
  logic [63:0] res;
  logic        illegal, out_vld;
  int vecs = 0, errs = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xsext_unit dut_i (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .src(src), .op(op),
    .xw_sel(xw_sel), .fixed_sz(fixed_sz), .res(res), .illegal(illegal), .out_vld(out_vld));

  function automatic logic [63:0] model(logic [63:0] s, logic [1:0] o, logic [1:0] w, logic f);
    int xl = 8 << w;
    int fs;
    logic [63:0] r = '0;
    if (o == 2'b11) fs = xl;
    else if (f) fs = ((8 << o) > xl) ? xl : (8 << o);
    else fs = xl / (8 >> o);
    for (int i = 0; i < 64; i++)
      if (i < fs) r[i] = s[i];
      else if (i < xl) r[i] = s[fs-1];
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [63:0] s, logic [1:0] o, logic [1:0] w, logic f, string tag);
    src = s; op = o; xw_sel = w; fixed_sz = f; in_vld = 1;
    @(posedge clk); #2;
    in_vld = 0;
    chk(tag, res, model(s, o, w, f));
    chk({tag, " R7 illegal"}, 64'(illegal), 64'(o == 2'b11));
    chk({tag, " R8 out_vld"}, 64'(out_vld), 64'd1);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(1234));
    repeat (2) @(posedge clk);
    #2;
    chk("R8 reset res", res, '0);
    chk("R8 reset vld", 64'(out_vld), '0);
    rst_n = 1;
    @(posedge clk); #2;
    apply(64'hFFFF_FFFF_FFFF_FF01, 2'b00, 2'd0, 0, "R2 R4 x8 1bit");
    chk("R2 value", res, 64'h0000_0000_0000_00FF);
    apply(64'hFFFF_FFFF_FFFF_FF02, 2'b01, 2'd0, 0, "R3 x8 2bit");
    chk("R3 value", res, 64'h0000_0000_0000_00FE);
    apply(64'h0000_0000_0000_0008, 2'b10, 2'd0, 0, "R3 x8 4bit");
    apply(64'h0000_0000_0000_0080, 2'b10, 2'd2, 0, "R3 x32 16bit pos");
    apply(64'h0000_0000_0000_8000, 2'b10, 2'd2, 0, "R3 R4 x32 16bit neg");
    apply(64'hABCD_0000_0000_0008, 2'b00, 2'd2, 0, "R2 R1 x32 4bit");
    apply(64'h0000_0000_0000_0080, 2'b00, 2'd0, 1, "R5 x8 legacy byte");
    chk("R5 passthrough", res, 64'h80);
    apply(64'h1234_5678_9ABC_DEF0, 2'b10, 2'd1, 1, "R5 x16 truncate");
    chk("R5 trunc value", res, 64'hDEF0);
    apply(64'h0000_0000_0000_0080, 2'b00, 2'd1, 1, "R5 x16 legacy byte");
    chk("R5 ext value", res, 64'hFF80);
    apply(64'h0000_0000_8000_0000, 2'b10, 2'd3, 1, "R6 x64 word legacy");
    chk("R6 equal modes", res, model(64'h8000_0000, 2'b10, 2'd3, 0));
    apply(64'hFEDC_BA98_7654_3210, 2'b11, 2'd1, 0, "R7 illegal pass");
    held = res;
    src = '1; op = 2'b00; @(posedge clk); #2;
    chk("R8 hold res", res, held);
    chk("R8 vld low", 64'(out_vld), 64'd0);
    for (int k = 0; k < 400; k++) begin
      logic [63:0] s = {$urandom, $urandom};
      logic [1:0] o = 2'($urandom);
      logic [1:0] w = 2'($urandom);
      logic f = 1'($urandom);
      apply(s, o, w, f, "R1 R2 R3 R5 random");
      if ($urandom % 4 == 0) begin
        held = res;
        src = ~s; @(posedge clk); #2;
        chk("R8 random hold", res, held);
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule